// File: doc/BRIEF.md
# Banked Internal Data RAM

This block holds a 128-byte on-chip data store and the access logic that lets one storage array be reached in four different ways. A plain byte access names any location by its direct address. The lowest 32 bytes are also seen as four groups of eight working registers. A two-bit bank register picks the group, so a register index 0 to 7 refers to byte `8*bank + index`. Sixteen bytes starting at 20h can also be handled one bit at a time through a 7-bit bit number. A 7-bit stack pointer builds an upward-growing stack anywhere in the array.

One operation is presented per clock on a 4-bit operation code, together with the operand fields that code needs. Writes, bit updates, pointer updates and bank changes take effect at the clock edge. Read results appear on a registered data output one cycle after the request, flagged by a valid strobe. The stack pointer and the bank register are brought out so that the pointer logic can be observed directly.

Top module: `banked_iram`

## Requirements
- R1: Once reset has been released, the stack pointer output reads 07h, the bank output reads 0 and the read-valid strobe is low.
- R2: Operation code 3 (register read) and code 4 (register write) address byte `8*bank + reg_idx`. A direct byte read of that address returns what a register write stored, whatever bank is active when the byte read is made.
- R3: Operation code 11 loads the bank register from `wdata_i[1:0]`. No other operation changes the bank.
- R4: A bit number b (codes 5, 6 and 7) selects byte `20h + (b >> 3)` and bit position `b[2:0]` inside it, so bit number 4Fh is bit 7 of byte 29h.
- R5: Codes 6 (bit set) and 7 (bit clear) change only the selected bit and leave the other seven bits of that byte unchanged.
- R6: Code 5 (bit read) returns the selected bit in `rdata_o[0]`, with `rdata_o[7:1]` zero.
- R7: Code 8 (push) first increments the stack pointer and then writes `wdata_i` at the new pointer value.
- R8: Code 9 (pop) reads the byte at the current stack pointer and decrements the pointer in the same operation.
- R9: The stack pointer is 7 bits wide. A push from 7Fh wraps it to 00h and a pop from 00h wraps it to 7Fh. Code 10 loads it from `wdata_i[6:0]`. Codes other than 8, 9 and 10 leave it unchanged.
- R10: Read codes (1, 3, 5 and 9) raise `rvalid_o` for exactly the following cycle, with the result on `rdata_o`. Any other cycle has `rvalid_o` low.
- R11: Code 1 (byte read) and code 2 (byte write) use `dir_addr_i[6:0]`. Bit 7 of the direct address is ignored. Code 0 and codes 12 to 15 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code for this cycle |
| dir_addr_i | input | 8 | Direct byte address (bit 7 ignored) |
| reg_idx_i | input | 3 | Working-register index within the active bank |
| bit_addr_i | input | 7 | Bit number for the bit operations |
| wdata_i | input | 8 | Write data, push data, pointer load or bank load |
| rdata_o | output | 8 | Registered read result |
| rvalid_o | output | 1 | rdata_o carries the result of the previous cycle's read |
| sp_o | output | 8 | Stack pointer (bit 7 always zero) |
| bank_o | output | 2 | Active register bank |

## Verification
The pointer update and the memory access that uses it fall in the same clock edge: a push moves the pointer and writes at the moved address together, and a pop reads at the old pointer while stepping it back. The bench provokes this with a pop issued on the very next cycle after a push, at the wrap points 7Fh and 00h, and over a long random stream of operations. A behavioural model keeps its own memory image and pointer, and it is compared with the pointer, bank, valid strobe and read data on every clock. A slip of one in the pointer, or a read taken from the wrong side of the update, therefore shows at the exact cycle where it happens.

// File: rtl/bram_pkg.sv
package bram_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_RD_BYTE = 4'd1,
    OP_WR_BYTE = 4'd2,
    OP_RD_REG  = 4'd3,
    OP_WR_REG  = 4'd4,
    OP_RD_BIT  = 4'd5,
    OP_SET_BIT = 4'd6,
    OP_CLR_BIT = 4'd7,
    OP_PUSH    = 4'd8,
    OP_POP     = 4'd9,
    OP_LD_SP   = 4'd10,
    OP_LD_BANK = 4'd11
  } op_e;

  function automatic logic op_is_read(op_e o);
    return (o == OP_RD_BYTE) || (o == OP_RD_REG) || (o == OP_RD_BIT) || (o == OP_POP);
  endfunction

endpackage

// File: rtl/bram_rst_sync.sv
module bram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/bram_ptr_regs.sv
module bram_ptr_regs
  import bram_pkg::*;
#(
  parameter int AW     = 7,
  parameter int BW     = 2,
  parameter int SP_RST = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [AW-1:0] sp_load,
  input  logic [BW-1:0] bank_load,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] sp_inc,
  output logic [BW-1:0] bank_q
);
  logic [AW-1:0] sp_d;
  logic          sp_en;
  logic          bank_en;

  assign sp_inc = sp_q + AW'(1);

  always_comb begin
    sp_en = 1'b0;
    sp_d  = sp_q;
    unique case (op)
      OP_PUSH:  begin sp_en = 1'b1; sp_d = sp_inc;         end
      OP_POP:   begin sp_en = 1'b1; sp_d = sp_q - AW'(1);  end
      OP_LD_SP: begin sp_en = 1'b1; sp_d = sp_load;        end
      default:  ;
    endcase
    bank_en = (op == OP_LD_BANK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= AW'(SP_RST);
    else if (sp_en) sp_q <= sp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_en) bank_q <= bank_load;
  end

  p_push_incr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH) |=> (sp_q == $past(sp_q) + AW'(1)));

  p_pop_decr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP) |=> (sp_q == $past(sp_q) - AW'(1)));

  p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op inside {OP_PUSH, OP_POP, OP_LD_SP}) |=> $stable(sp_q));

  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_LD_BANK) |=> $stable(bank_q));
endmodule

// File: rtl/bram_addr_map.sv
module bram_addr_map
  import bram_pkg::*;
#(
  parameter int AW       = 7,
  parameter int RW       = 3,
  parameter int BW       = 2,
  parameter int BPW      = 3,
  parameter int BIT_BASE = 32
) (
  input  op_e            op,
  input  logic [AW-1:0]  dir_addr,
  input  logic [RW-1:0]  reg_idx,
  input  logic [BW-1:0]  bank,
  input  logic [AW-1:0]  bit_addr,
  input  logic [AW-1:0]  sp_q,
  input  logic [AW-1:0]  sp_inc,
  output logic [AW-1:0]  addr,
  output logic [BPW-1:0] bit_pos
);
  localparam int REG_AW = RW + BW;

  logic [AW-1:0] reg_addr;
  logic [AW-1:0] bit_byte;

  assign reg_addr = AW'({bank, reg_idx});
  assign bit_byte = AW'(BIT_BASE) + AW'(bit_addr >> BPW);
  assign bit_pos  = bit_addr[BPW-1:0];

  always_comb begin
    unique case (op)
      OP_RD_REG, OP_WR_REG:              addr = reg_addr;
      OP_RD_BIT, OP_SET_BIT, OP_CLR_BIT: addr = bit_byte;
      OP_PUSH:                           addr = sp_inc;
      OP_POP:                            addr = sp_q;
      default:                           addr = dir_addr;
    endcase
  end

  initial begin
    assert (REG_AW <= AW) else $error("register space wider than address");
  end
endmodule

// File: rtl/bram_store.sv
module bram_store
  import bram_pkg::*;
#(
  parameter int AW  = 7,
  parameter int DW  = 8,
  parameter int BPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  op_e            op,
  input  logic [AW-1:0]  addr,
  input  logic [BPW-1:0] bit_pos,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata_q,
  output logic           rvalid_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] cur;
  logic [DW-1:0] mask;
  logic [DW-1:0] wbyte;
  logic [DW-1:0] rd_byte;
  logic          we;
  logic          rd_en;

  assign cur  = mem_q[addr];
  assign mask = DW'(1) << bit_pos;

  always_comb begin
    we    = 1'b0;
    wbyte = wdata;
    unique case (op)
      OP_WR_BYTE, OP_WR_REG, OP_PUSH: we = 1'b1;
      OP_SET_BIT: begin we = 1'b1; wbyte = cur | mask;  end
      OP_CLR_BIT: begin we = 1'b1; wbyte = cur & ~mask; end
      default: ;
    endcase
    rd_en   = op_is_read(op);
    rd_byte = (op == OP_RD_BIT) ? {{(DW-1){1'b0}}, cur[bit_pos]} : cur;
  end

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_byte;
    end
  end

  p_set_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET_BIT) |=> (mem_q[$past(addr)] == ($past(cur) | $past(mask))));

  p_clr_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR_BIT) |=> (mem_q[$past(addr)] == ($past(cur) & ~$past(mask))));

  p_push_stores_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH) |=> (mem_q[$past(addr)] == $past(wdata)));

  p_bitread_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD_BIT) |=> (rvalid_q && (rdata_q[DW-1:1] == '0)));
endmodule

// File: rtl/banked_iram.sv
module banked_iram
  import bram_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 7,
  parameter int PW       = 8,
  parameter int RW       = 3,
  parameter int BW       = 2,
  parameter int BIT_BASE = 32,
  parameter int SP_RST   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic [PW-1:0] dir_addr_i,
  input  logic [RW-1:0] reg_idx_i,
  input  logic [AW-1:0] bit_addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic [PW-1:0] sp_o,
  output logic [BW-1:0] bank_o
);
  localparam int BPW = $clog2(DW);

  op_e            op_c;
  logic           rst_sync_n;
  logic [AW-1:0]  sp_q;
  logic [AW-1:0]  sp_inc;
  logic [BW-1:0]  bank_q;
  logic [AW-1:0]  addr;
  logic [BPW-1:0] bit_pos;
  logic           unused_hi_addr;

  assign op_c           = op_e'(op_i);
  assign unused_hi_addr = ^dir_addr_i[PW-1:AW];

  bram_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bram_ptr_regs #(.AW(AW), .BW(BW), .SP_RST(SP_RST)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op        (op_c),
    .sp_load   (wdata_i[AW-1:0]),
    .bank_load (wdata_i[BW-1:0]),
    .sp_q      (sp_q),
    .sp_inc    (sp_inc),
    .bank_q    (bank_q)
  );

  bram_addr_map #(.AW(AW), .RW(RW), .BW(BW), .BPW(BPW), .BIT_BASE(BIT_BASE)) u_map (
    .op       (op_c),
    .dir_addr (dir_addr_i[AW-1:0]),
    .reg_idx  (reg_idx_i),
    .bank     (bank_q),
    .bit_addr (bit_addr_i),
    .sp_q     (sp_q),
    .sp_inc   (sp_inc),
    .addr     (addr),
    .bit_pos  (bit_pos)
  );

  bram_store #(.AW(AW), .DW(DW), .BPW(BPW)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op       (op_c),
    .addr     (addr),
    .bit_pos  (bit_pos),
    .wdata    (wdata_i),
    .rdata_q  (rdata_o),
    .rvalid_q (rvalid_o)
  );

  assign sp_o   = PW'(sp_q);
  assign bank_o = bank_q;

  p_read_strobe_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_is_read(op_c) |=> rvalid_o);

  p_idle_strobe_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_is_read(op_c) |=> !rvalid_o);

  p_sp_msb_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_c == OP_LD_SP) |=> (sp_o[PW-1:AW] == '0) && (sp_o[AW-1:0] == $past(wdata_i[AW-1:0])));
endmodule

// File: tb/banked_iram_bench.sv
`timescale 1ns/1ps
module banked_iram_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_i;
  logic [7:0] dir_addr_i;
  logic [2:0] reg_idx_i;
  logic [6:0] bit_addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       rvalid_o;
  logic [7:0] sp_o;
  logic [1:0] bank_o;

  int checks   = 0;
  int failures = 0;

  int m_mem [128];
  int m_sp;
  int m_bank;
  int m_rvalid;
  int m_rdata;

  always #2 clk = ~clk;

  banked_iram u_banked_iram (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .dir_addr_i(dir_addr_i),
    .reg_idx_i(reg_idx_i), .bit_addr_i(bit_addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .sp_o(sp_o), .bank_o(bank_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive one operation at the falling edge, advance the model, compare after the rising edge.
  task automatic do_op(int o, int a, int r, int b, int d, string tag);
    int byte_a;
    @(negedge clk);
    op_i = 4'(o); dir_addr_i = 8'(a); reg_idx_i = 3'(r); bit_addr_i = 7'(b); wdata_i = 8'(d);
    m_rvalid = 0;
    byte_a   = 32 + ((b & 127) >> 3);
    case (o)
      1:  begin m_rvalid = 1; m_rdata = m_mem[a & 127]; end
      2:  m_mem[a & 127] = d & 255;
      3:  begin m_rvalid = 1; m_rdata = m_mem[m_bank * 8 + r]; end
      4:  m_mem[m_bank * 8 + r] = d & 255;
      5:  begin m_rvalid = 1; m_rdata = (m_mem[byte_a] >> (b & 7)) & 1; end
      6:  m_mem[byte_a] = m_mem[byte_a] | (1 << (b & 7));
      7:  m_mem[byte_a] = m_mem[byte_a] & ~(1 << (b & 7)) & 255;
      8:  begin m_sp = (m_sp + 1) & 127; m_mem[m_sp] = d & 255; end
      9:  begin m_rvalid = 1; m_rdata = m_mem[m_sp]; m_sp = (m_sp + 127) & 127; end
      10: m_sp = d & 127;
      11: m_bank = d & 3;
      default: ;
    endcase
    @(posedge clk);
    #1;
    chk(tag, "rvalid", int'(rvalid_o), m_rvalid);
    if (m_rvalid != 0) chk(tag, "rdata", int'(rdata_o), m_rdata);
    chk(tag, "sp", int'(sp_o), m_sp);
    chk(tag, "bank", int'(bank_o), m_bank);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    op_i = 4'd0; dir_addr_i = '0; reg_idx_i = '0; bit_addr_i = '0; wdata_i = '0;
    m_sp = 7; m_bank = 0; m_rvalid = 0; m_rdata = 0;
    for (int i = 0; i < 128; i++) m_mem[i] = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: state after reset release
    chk("R1", "sp", int'(sp_o), 7);
    chk("R1", "bank", int'(bank_o), 0);
    chk("R1", "rvalid", int'(rvalid_o), 0);

    // R11: fill every byte, odd addresses with bit 7 of the direct address set
    for (int i = 0; i < 128; i++) do_op(2, i | ((i & 1) << 7), 0, 0, (i * 37 + 5) & 255, "R11");
    do_op(1, 8'h85, 0, 0, 0, "R11");
    do_op(1, 8'h7F, 0, 0, 0, "R11");
    do_op(0, 0, 0, 0, 0, "R11");
    do_op(13, 8'h10, 0, 0, 8'hEE, "R11");
    do_op(1, 8'h10, 0, 0, 0, "R11");

    // R2 / R3: bank aliasing
    do_op(11, 0, 0, 0, 8'hFE, "R3");
    do_op(4, 0, 5, 0, 8'hA5, "R2");
    do_op(11, 0, 0, 0, 8'h00, "R3");
    do_op(1, 21, 0, 0, 0, "R2");
    do_op(3, 0, 5, 0, 0, "R2");
    do_op(11, 0, 0, 0, 3, "R3");
    do_op(3, 0, 7, 0, 0, "R2");
    do_op(11, 0, 0, 0, 2, "R3");
    do_op(3, 0, 5, 0, 0, "R2");

    // R4 / R5 / R6: bit access, bit 4Fh is bit 7 of byte 29h
    do_op(2, 8'h29, 0, 0, 8'h12, "R4");
    do_op(6, 0, 0, 8'h4F, 0, "R5");
    do_op(1, 8'h29, 0, 0, 0, "R4");
    do_op(5, 0, 0, 8'h4F, 0, "R6");
    do_op(7, 0, 0, 8'h49, 0, "R5");
    do_op(1, 8'h29, 0, 0, 0, "R5");
    do_op(5, 0, 0, 8'h00, 0, "R6");
    do_op(6, 0, 0, 8'h7F, 0, "R4");
    do_op(1, 8'h2F, 0, 0, 0, "R4");

    // R7 / R8: push then pop on the next cycle
    do_op(8, 0, 0, 0, 8'h3C, "R7");
    do_op(9, 0, 0, 0, 0, "R8");
    do_op(8, 0, 0, 0, 8'h11, "R7");
    do_op(8, 0, 0, 0, 8'h22, "R7");
    do_op(9, 0, 0, 0, 0, "R8");
    do_op(9, 0, 0, 0, 0, "R8");

    // R9: pointer wrap at both ends, load masks bit 7
    do_op(10, 0, 0, 0, 8'hFF, "R9");
    do_op(8, 0, 0, 0, 8'h5A, "R9");
    do_op(1, 0, 0, 0, 0, "R9");
    do_op(9, 0, 0, 0, 0, "R9");
    do_op(9, 0, 0, 0, 0, "R9");
    do_op(10, 0, 0, 0, 8'h00, "R9");
    do_op(9, 0, 0, 0, 0, "R9");

    // R10: long random stream against the model
    for (int i = 0; i < 3000; i++) begin
      do_op(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)), int'($urandom_range(0, 7)),
            int'($urandom_range(0, 127)), int'($urandom_range(0, 255)), "R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule